// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed 32-bit integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a mantissa whose top bit is the explicit leading one. The operand's value is `mant * 2^(exp - (MANT_W-1))`. The conversion always chops toward zero; no other rounding direction exists in the block.

Alongside the integer, two flags come out. The inexact flag reports that fractional bits were dropped. The operand-error flag reports that the value cannot be represented. When the operand-error flag is raised, the result saturates according to the sign and the inexact flag is forced low. An input word is taken when `in_valid` is high. The registered result and its flags appear one clock later with `out_valid`.

Top module: `fp_trunc_to_int`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge; otherwise `out_valid` is low. The result and flags keep their values across any edge at which `in_valid` is low.
- R2: Class codes are 0 = zero, 1 = normal, 2 = infinity, 3 = quiet NaN and 4 = signalling NaN; codes 5 to 7 are handled like NaN. A class-0 operand gives result 0 with both flags low, whatever its sign, exponent and mantissa.
- R3: Classes 2 through 7 give operand error = 1, inexact = 0, and a result of 0x7FFFFFFF when the sign is 0 or 0x80000000 when the sign is 1.
- R4: For a normal operand that does not overflow, the result is the integer part of `mant * 2^(exp-(MANT_W-1))`, truncated toward zero, in two's complement, and negated when the sign is 1.
- R5: For a normal operand that does not overflow, inexact is 1 exactly when a nonzero bit was dropped below the integer part. Operand error stays 0.
- R6: A normal operand with an exponent of 32 or more is an overflow.
- R7: A normal operand whose truncated magnitude exceeds 0x80000000 is an overflow. A magnitude equal to 0x80000000 is an overflow when the sign is 0. With sign 1 it gives the result 0x80000000 with no operand error.
- R8: On any overflow, operand error is 1 and inexact is 0, even when bits were dropped. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R9: A normal operand with a negative exponent gives result 0. Its inexact flag is 1 exactly when the mantissa is nonzero.
- R10: After reset, `out_valid`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Operand class code |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, leading one at bit MANT_W-1 |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Signed integer result |
| out_inexact | output | 1 | Bits were dropped by truncation |
| out_operr | output | 1 | Operand not representable; result saturated |

## Verification
The bench builds the block with MANT_W = 40 and EXP_W = 8. With these values, every exponent from -128 to 127 can be drawn at random. Shift distances on both sides of the 32-bit window are hit often, including the points where the mantissa lies fully inside the integer part and where it lies fully in the discarded fraction. The narrow mantissa also makes exact results likely. Clearing random low bits produces them, so the inexact flag is exercised in both states near the ±2^31 boundary.

// File: rtl/fp_trunc_to_int.sv
module fp_trunc_to_int #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  output logic                    out_valid,
  output logic [31:0]             out_result,
  output logic                    out_inexact,
  output logic                    out_operr
);
  localparam int EXT_W   = MANT_W + 32;
  localparam int SH_W    = $clog2(EXT_W + 1);
  localparam int SH_BASE = MANT_W + 31;
  localparam logic [SH_W-1:0] SH_BASE_V = SH_W'(SH_BASE);

  localparam logic [2:0] CLS_ZERO   = 3'd0;
  localparam logic [2:0] CLS_NORMAL = 3'd1;

  logic              exp_neg, exp_big;
  logic [SH_W-1:0]   sh;
  logic [EXT_W-1:0]  ext, shifted;
  logic [31:0]       mag, sat;
  logic              sticky, mag_ovf, ovf;
  logic [31:0]       nxt_result;
  logic              nxt_inexact, nxt_operr;

  assign exp_neg = in_exp[EXP_W-1];
  assign exp_big = !exp_neg && (|in_exp[EXP_W-2:5]);
  assign ext     = {in_mant, 32'b0};
  assign sh      = SH_BASE_V - {{(SH_W-5){1'b0}}, in_exp[4:0]};
  assign shifted = ext >> sh;
  assign mag     = exp_neg ? 32'd0 : shifted[31:0];
  assign sticky  = exp_neg ? (|in_mant) : ((shifted << sh) != ext);
  assign mag_ovf = {1'b0, mag} >= (33'h0_8000_0000 + {32'b0, in_sign});
  assign sat     = 32'h7FFF_FFFF + {31'b0, in_sign};

  always_comb begin
    nxt_result  = 32'd0;
    nxt_inexact = 1'b0;
    nxt_operr   = 1'b0;
    ovf         = 1'b0;
    if (in_class == CLS_ZERO) begin
      nxt_result = 32'd0;
    end else if (in_class == CLS_NORMAL) begin
      ovf = exp_big || mag_ovf;
      if (ovf) begin
        nxt_result = sat;
        nxt_operr  = 1'b1;
      end else begin
        nxt_result  = in_sign ? (~mag + 32'd1) : mag;
        nxt_inexact = sticky;
      end
    end else begin
      nxt_result = sat;
      nxt_operr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= 32'd0;
      out_inexact <= 1'b0;
      out_operr   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_inexact <= nxt_inexact;
        out_operr   <= nxt_operr;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_inexact) && $stable(out_operr)); // R1
  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 3'd0 |=> out_result == 32'd0 && !out_inexact && !out_operr); // R2
  AST_NONNUM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class >= 3'd2 |=>
      out_operr && !out_inexact &&
      out_result == ($past(in_sign) ? 32'h8000_0000 : 32'h7FFF_FFFF)); // R3
  AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 3'd1 && !in_exp[EXP_W-1] && in_exp >= EXP_W'(32) |=>
      out_operr); // R6
  AST_OVF_NO_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_operr |-> !out_inexact); // R8
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_operr |-> out_result == 32'h7FFF_FFFF || out_result == 32'h8000_0000); // R8
  AST_NEG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 3'd1 && in_exp[EXP_W-1] |=>
      out_result == 32'd0 && !out_operr && out_inexact == ($past(in_mant) != '0)); // R9
endmodule

// File: tb/tb_fp_trunc_to_int.sv
`timescale 1ns/1ps
module tb_fp_trunc_to_int;
  localparam int MW = 40;
  localparam int EW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [2:0]           in_class = '0;
  logic                 in_sign = 1'b0;
  logic signed [EW-1:0] in_exp = '0;
  logic [MW-1:0]        in_mant = '0;
  logic                 out_valid;
  logic [31:0]          out_result;
  logic                 out_inexact, out_operr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_trunc_to_int #(.MANT_W(MW), .EXP_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_operr(out_operr));

  function automatic logic [33:0] model(input logic [2:0] cls, input logic sg,
                                        input int e, input logic [MW-1:0] m);
    logic [127:0] wide, frac;
    logic [31:0]  mag;
    logic         stk;
    int           s;
    if (cls == 3'd0) return 34'd0;
    if (cls != 3'd1) return {(sg ? 32'h8000_0000 : 32'h7FFF_FFFF), 1'b0, 1'b1};
    if (e >= 32) return {(sg ? 32'h8000_0000 : 32'h7FFF_FFFF), 1'b0, 1'b1};
    if (e < 0) return {32'd0, (m != '0), 1'b0};
    s    = MW - 1 - e;
    wide = {88'd0, m};
    mag  = 32'(wide >> s);
    frac = wide & ((128'd1 << s) - 128'd1);
    stk  = frac != 128'd0;
    if (mag > 32'h8000_0000 || (mag == 32'h8000_0000 && !sg))
      return {(sg ? 32'h8000_0000 : 32'h7FFF_FFFF), 1'b0, 1'b1};
    return {(sg ? (~mag + 32'd1) : mag), stk, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual res=%h inx=%0b oe=%0b expected res=%h inx=%0b oe=%0b",
               tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] c, input logic sg,
                       input int e, input logic [MW-1:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_sign = sg; in_exp = EW'(e); in_mant = m;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {33'd0, out_valid}, 34'd1);
    check(tag, {out_result, out_inexact, out_operr}, model(c, sg, e, m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [33:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 reset", {out_result, out_inexact, out_operr}, 34'd0);
    check("R10 reset valid", {33'd0, out_valid}, 34'd0);
    rst_n = 1'b1;

    apply("R2 zero", 3'd0, 1'b1, 20, {1'b1, 39'h55});
    apply("R3 +inf", 3'd2, 1'b0, 5, '0);
    apply("R3 -qnan", 3'd3, 1'b1, 0, {MW{1'b1}});
    apply("R3 snan", 3'd4, 1'b0, -3, '0);
    apply("R3 code7", 3'd7, 1'b1, 0, '0);
    apply("R4 one", 3'd1, 1'b0, 0, {1'b1, 39'd0});
    apply("R4 -2.5", 3'd1, 1'b1, 1, {3'b101, 37'd0});
    apply("R5 exact", 3'd1, 1'b0, 10, {1'b1, 39'd0});
    apply("R6 exp32", 3'd1, 1'b1, 32, {1'b1, 39'd0});
    apply("R6 exp127", 3'd1, 1'b0, 127, {1'b1, 39'd0});
    apply("R7 -2^31", 3'd1, 1'b1, 31, {1'b1, 39'd0});
    apply("R7 +2^31", 3'd1, 1'b0, 31, {1'b1, 39'd0});
    apply("R7 -2^31 frac", 3'd1, 1'b1, 31, {1'b1, 38'd0, 1'b1});
    apply("R8 max inexact", 3'd1, 1'b0, 31, {MW{1'b1}});
    apply("R4 max pos", 3'd1, 1'b0, 30, {MW{1'b1}});
    apply("R9 half", 3'd1, 1'b1, -1, {1'b1, 39'd0});
    apply("R9 zero mant", 3'd1, 1'b0, -128, '0);
    apply("R5 zero mant", 3'd1, 1'b0, 7, '0);

    @(negedge clk);
    held = {out_result, out_inexact, out_operr};
    in_valid = 1'b0; in_class = 3'd2; in_sign = ~in_sign; in_exp = 8'sd3; in_mant = '1;
    @(negedge clk);
    check("R1 hold", {out_result, out_inexact, out_operr}, held);
    check("R1 idle valid", {33'd0, out_valid}, 34'd0);

    for (int i = 0; i < 3000; i++) begin
      int r, e, k;
      logic [2:0] c;
      logic [MW-1:0] m;
      r = int'($urandom % 16);
      c = (r == 0) ? 3'd0 : (r == 1) ? 3'd2 : (r == 2) ? 3'd3 : (r == 3) ? 3'd4 :
          (r == 4) ? 3'(5 + $urandom % 3) : 3'd1;
      if ($urandom % 4 == 0) e = int'($urandom % 256) - 128;
      else e = int'($urandom % 80) - 40;
      m = {1'b1, 7'($urandom), 32'($urandom)};
      k = int'($urandom % MW);
      if ($urandom % 2 == 0) m = m & ~((40'd1 << k) - 40'd1);
      if ($urandom % 32 == 0) m = '0;
      apply(c == 3'd1 ? (e < 0 ? "R9 rand" : "R5 rand") : "R3 rand", c, 1'($urandom), e, m);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule